// File: doc/BRIEF.md
# Parallel Configuration Loader for a Target FPGA

This block lives in a glue device placed between a production tester, a byte-wide parallel flash and an FPGA under test. The tester gives it an inclusive flash address window and a one-cycle start pulse. The loader then runs the target's configuration handshake from start to finish. It pulls the active-low program line low for a set time. It waits for the target to report that its configuration memory is clear, which the target does by releasing the active-low init line. It then asserts the active-low chip select and copies the window byte by byte from flash to the target's eight data pins, reversing the bit order of each byte. After the last byte it gives the target a burst of extra clock pulses and waits for the done line to rise.

Several images can sit in different windows of one flash. The tester can therefore configure the same target with many images in a row, and test it after each load, without removing power. Each stored image must open with an eight-byte synchronisation pattern. The loader checks these bytes as they pass through. Three status flags report the outcome to the tester: busy, done and error, with a 3-bit error code. The outcome flags keep their values until the next accepted start.

The flash side is fixed-latency with no back-pressure. The loader issues one read strobe with an address and takes the data exactly `LAT` cycles later. It issues no further read until that byte has been written, so no more than one read is ever outstanding. The target side is a plain strobe with no back-pressure: one `cclk_o` pulse per byte while chip select is low.

Top module: `cfgload_seq`

## Requirements
- R1: A start pulse is accepted only while `busy_o` is low. `busy_o` rises on the cycle after an accepted start and stays high until the run ends. A start pulse seen while busy has no effect on the run.
- R2: Each run drives `prog_n_o` low for exactly `PROG_CYC` cycles (default 16), once per run.
- R3: `cs_n_o` goes low only after `init_n_i` has been seen high, and never while `prog_n_o` is low. If `init_n_i` stays low for `INIT_TO` cycles (default 256), the run ends with error code 1 and no bytes are written.
- R4: The loader reads every flash address from the base address to the last address inclusive, in ascending order, with one read per byte. It samples the data `LAT` cycles after each read and gives one single-cycle `cclk_o` pulse per byte while `cs_n_o` is low, so the bytes reach the target in address order.
- R5: Bit k of each flash byte is driven on `cfg_data_o[7-k]`.
- R6: The first eight bytes must be FF FF FF FF AA 99 55 66, compared with the flash byte as stored. On the first byte that differs, the run ends with error code 2, and that byte is not written.
- R7: A window shorter than eight bytes ends with error code 5, after all of its bytes have been written.
- R8: If `init_n_i` falls while bytes are being transferred, the run ends with error code 3 and no further byte is written.
- R9: After the last byte, exactly `SU_PULSES` (default 8) `cclk_o` pulses are issued with `cs_n_o` high. The loader then waits for `done_i`. If `done_i` is seen high, `done_o` is set. If it is not seen within `DONE_TO` cycles (default 256), the run ends with error code 4.
- R10: `done_o`, `err_o` and `err_code_o` keep their values until the next accepted start, which clears all three. `done_o` and `err_o` are never high together.
- R11: While idle, `prog_n_o` and `cs_n_o` are high and `cclk_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start command from the tester |
| base_addr_i | input | AW | First flash address of the image |
| last_addr_i | input | AW | Last flash address of the image (inclusive, not below base) |
| flash_rd_o | output | 1 | Flash read strobe, one cycle per byte |
| flash_addr_o | output | AW | Flash byte address |
| flash_data_i | input | 8 | Flash data, valid LAT cycles after the read strobe |
| prog_n_o | output | 1 | Active-low program request to the target |
| init_n_i | input | 1 | Active-low init status from the target |
| done_i | input | 1 | Configuration-done status from the target |
| cs_n_o | output | 1 | Active-low chip select to the target |
| cclk_o | output | 1 | Configuration clock / write strobe to the target |
| cfg_data_o | output | 8 | Bit-reversed configuration byte |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The last run completed successfully |
| err_o | output | 1 | The last run ended in error |
| err_code_o | output | 3 | Cause: 1 init timeout, 2 bad sync, 3 init lost, 4 done timeout, 5 short image |

## Verification
The assertions assume that `init_n_i` and `done_i` are synchronous to `clk` and follow the target's behaviour: both go low while program is low, and init returns high only after program is released. They also assume that flash data arrives exactly `LAT` cycles after each read and that `base_addr_i` is not above `last_addr_i`. The stimulus meets these assumptions by driving both target status lines from a clocked target model in the bench and by serving flash reads from a pipeline of `LAT` stages. The start pulse is the only input the bench drives freely. It is applied both in idle and in the middle of a run.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_WINIT, S_READ, S_LAT, S_WRITE, S_STARTUP, S_WDONE
  } seq_st_e;

  typedef enum logic [2:0] {
    E_NONE      = 3'd0,
    E_INIT_TO   = 3'd1,
    E_SYNC      = 3'd2,
    E_INIT_LOST = 3'd3,
    E_DONE_TO   = 3'd4,
    E_SHORT     = 3'd5
  } err_e;

  localparam int unsigned SYNC_LEN = 8;

  // expected stored byte at each position of the opening pattern
  function automatic logic [7:0] sync_byte(input logic [2:0] idx);
    case (idx)
      3'd4:    sync_byte = 8'hAA;
      3'd5:    sync_byte = 8'h99;
      3'd6:    sync_byte = 8'h55;
      3'd7:    sync_byte = 8'h66;
      default: sync_byte = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgload_timer.sv
module cfgload_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [TW-1:0] cnt
);
  // cycles spent in the current state, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cfgload_addr_gen.sv
module cfgload_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] last,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          at_last
);
  logic [AW-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      last_q <= '0;
    end else if (load) begin
      addr   <= base;
      last_q <= last;
    end else if (step) begin
      addr   <= addr + 1'b1;
    end
  end

  assign at_last = (addr == last_q);
endmodule

// File: rtl/cfgload_byte_path.sv
module cfgload_byte_path
  import cfgload_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       cap,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       sync_ok,
  output logic       sync_full
);
  localparam int IW = $clog2(SYNC_LEN) + 1;

  logic [7:0]    data_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      idx_q  <= '0;
    end else if (clr) begin
      idx_q  <= '0;
    end else if (cap) begin
      data_q <= din;
      if (!sync_full) idx_q <= idx_q + 1'b1;
    end
  end

  assign sync_full = (idx_q == IW'(SYNC_LEN));
  assign sync_ok   = sync_full || (din == sync_byte(idx_q[2:0]));

  // target reads flash bit k on its pin 7-k
  for (genvar k = 0; k < 8; k++) begin : g_rev
    assign dout[k] = data_q[7-k];
  end
endmodule

// File: rtl/cfgload_seq.sv
module cfgload_seq
  import cfgload_pkg::*;
#(
  parameter int AW        = 16,
  parameter int LAT       = 2,
  parameter int PROG_CYC  = 16,
  parameter int SU_PULSES = 8,
  parameter int INIT_TO   = 256,
  parameter int DONE_TO   = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [AW-1:0] last_addr_i,
  output logic          flash_rd_o,
  output logic [AW-1:0] flash_addr_o,
  input  logic [7:0]    flash_data_i,
  output logic          prog_n_o,
  input  logic          init_n_i,
  input  logic          done_i,
  output logic          cs_n_o,
  output logic          cclk_o,
  output logic [7:0]    cfg_data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [2:0]    err_code_o
);
  localparam int M1   = (PROG_CYC > INIT_TO) ? PROG_CYC : INIT_TO;
  localparam int M2   = (DONE_TO > 2*SU_PULSES) ? DONE_TO : 2*SU_PULSES;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXV = (M3 > LAT) ? M3 : LAT;
  localparam int TW   = $clog2(MAXV + 1) + 1;

  localparam logic [TW-1:0] T_PROG = TW'(PROG_CYC - 1);
  localparam logic [TW-1:0] T_INIT = TW'(INIT_TO - 1);
  localparam logic [TW-1:0] T_LAT  = TW'(LAT - 1);
  localparam logic [TW-1:0] T_SU   = TW'(2*SU_PULSES - 1);
  localparam logic [TW-1:0] T_DONE = TW'(DONE_TO - 1);

  seq_st_e st_q, st_d;
  err_e    err_q, err_d;
  logic    done_q, errf_q;
  logic    set_err, set_done, load, step, cap;
  logic [TW-1:0] tcnt;
  logic    at_last, sync_ok, sync_full;
  logic [AW-1:0] addr;

  cfgload_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(st_d != st_q), .cnt(tcnt)
  );

  cfgload_addr_gen #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .base(base_addr_i),
    .last(last_addr_i), .step(step), .addr(addr), .at_last(at_last)
  );

  cfgload_byte_path u_bytes (
    .clk(clk), .rst_n(rst_n), .clr(load), .cap(cap), .din(flash_data_i),
    .dout(cfg_data_o), .sync_ok(sync_ok), .sync_full(sync_full)
  );

  always_comb begin
    st_d     = st_q;
    err_d    = E_NONE;
    set_err  = 1'b0;
    set_done = 1'b0;
    load     = 1'b0;
    step     = 1'b0;
    cap      = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        load = 1'b1;
        st_d = S_PROG;
      end
      S_PROG: if (tcnt == T_PROG) st_d = S_WINIT;
      S_WINIT: begin
        if (init_n_i)             st_d = S_READ;
        else if (tcnt == T_INIT) begin set_err = 1'b1; err_d = E_INIT_TO; end
      end
      S_READ: begin
        if (!init_n_i) begin set_err = 1'b1; err_d = E_INIT_LOST; end
        else           st_d = S_LAT;
      end
      S_LAT: begin
        if (!init_n_i) begin
          set_err = 1'b1; err_d = E_INIT_LOST;
        end else if (tcnt == T_LAT) begin
          if (!sync_ok) begin set_err = 1'b1; err_d = E_SYNC; end
          else begin cap = 1'b1; st_d = S_WRITE; end
        end
      end
      S_WRITE: begin
        if (!at_last) begin
          step = 1'b1;
          st_d = S_READ;
        end else if (!sync_full) begin
          set_err = 1'b1; err_d = E_SHORT;
        end else begin
          st_d = S_STARTUP;
        end
      end
      S_STARTUP: if (tcnt == T_SU) st_d = S_WDONE;
      S_WDONE: begin
        if (done_i) begin
          set_done = 1'b1;
          st_d     = S_IDLE;
        end else if (tcnt == T_DONE) begin
          set_err = 1'b1; err_d = E_DONE_TO;
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (set_err) st_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      done_q <= 1'b0;
      errf_q <= 1'b0;
      err_q  <= E_NONE;
    end else begin
      st_q <= st_d;
      if (load) begin
        done_q <= 1'b0;
        errf_q <= 1'b0;
        err_q  <= E_NONE;
      end else if (set_err) begin
        errf_q <= 1'b1;
        err_q  <= err_d;
      end else if (set_done) begin
        done_q <= 1'b1;
      end
    end
  end

  assign busy_o       = (st_q != S_IDLE);
  assign prog_n_o     = (st_q != S_PROG);
  assign cs_n_o       = !(st_q == S_READ || st_q == S_LAT || st_q == S_WRITE);
  assign cclk_o       = (st_q == S_WRITE) || (st_q == S_STARTUP && tcnt[0]);
  assign flash_rd_o   = (st_q == S_READ);
  assign flash_addr_o = addr;
  assign done_o       = done_q;
  assign err_o        = errf_q;
  assign err_code_o   = err_q;
endmodule

// File: rtl/cfgload_seq_chk.sv
module cfgload_seq_chk #(
  parameter int PROG_CYC = 16
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic prog_n_o,
  input logic cs_n_o,
  input logic cclk_o,
  input logic flash_rd_o,
  input logic init_n_i
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= '0;
    else if (prog_n_o)   low_cnt <= '0;
    else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
  end

  p_busy_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o);

  p_prog_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n_o) |-> low_cnt == 16'(PROG_CYC));

  p_cs_after_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> $past(init_n_i));

  p_no_cs_in_prog_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> cs_n_o);

  p_single_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flash_rd_o |=> !flash_rd_o);

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_o && !cs_n_o |=> !cclk_o);

  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> $stable(done_o) && $stable(err_o));

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> prog_n_o && cs_n_o && !cclk_o);
endmodule

bind cfgload_seq cfgload_seq_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .prog_n_o(prog_n_o), .cs_n_o(cs_n_o),
  .cclk_o(cclk_o), .flash_rd_o(flash_rd_o), .init_n_i(init_n_i)
);

// File: tb/cfgload_seq_tb.sv
module cfgload_seq_tb;
  localparam int CLR = 10;

  typedef struct packed {
    logic [15:0] base;
    logic [15:0] last;
    logic        init_ok;
    logic        done_ok;
    logic [7:0]  drop;
    logic [2:0]  err;
    logic [7:0]  nbytes;
    logic [7:0]  nsu;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'd0,  16'd15, 1'b1, 1'b1, 8'd0, 3'd0, 8'd16, 8'd8},  // R4 R5 R9 good image A
    '{16'd32, 16'd43, 1'b1, 1'b1, 8'd0, 3'd0, 8'd12, 8'd8},  // R4 R5 image B
    '{16'd16, 16'd23, 1'b1, 1'b1, 8'd0, 3'd2, 8'd3,  8'd0},  // R6 bad sync
    '{16'd48, 16'd52, 1'b1, 1'b1, 8'd0, 3'd5, 8'd5,  8'd0},  // R7 short
    '{16'd0,  16'd15, 1'b0, 1'b1, 8'd0, 3'd1, 8'd0,  8'd0},  // R3 init timeout
    '{16'd0,  16'd15, 1'b1, 1'b0, 8'd0, 3'd4, 8'd16, 8'd8},  // R9 done timeout
    '{16'd0,  16'd15, 1'b1, 1'b1, 8'd3, 3'd3, 8'd3,  8'd0}   // R8 init lost
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] base = '0, last = '0;
  logic flash_rd, prog_n, cs_n, cclk, busy, done, err;
  logic [15:0] faddr;
  logic [7:0] fdata, cdata;
  logic [2:0] ecode;
  logic t_init, t_done;

  int checks = 0, errors = 0;
  logic [7:0] mem [64];
  logic [7:0] cap [64];
  logic [7:0] p1, p2;
  int ncap, nsu, clr_cnt, plow, plow_last, nfall, cyc;
  logic dropped, m_init_ok, m_done_ok, m_clr;
  logic [7:0] m_drop;

  always #10 clk = ~clk;

  cfgload_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base),
    .last_addr_i(last), .flash_rd_o(flash_rd), .flash_addr_o(faddr),
    .flash_data_i(fdata), .prog_n_o(prog_n), .init_n_i(t_init),
    .done_i(t_done), .cs_n_o(cs_n), .cclk_o(cclk), .cfg_data_o(cdata),
    .busy_o(busy), .done_o(done), .err_o(err), .err_code_o(ecode)
  );

  // flash: two-stage read pipeline
  always @(posedge clk) begin
    p1 <= mem[faddr[5:0]];
    p2 <= p1;
  end
  assign fdata = p2;

  // target model and monitors
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n || m_clr) begin
      t_init <= 1'b1; t_done <= 1'b0; ncap <= 0; nsu <= 0; clr_cnt <= 0;
      dropped <= 1'b0; plow <= 0; nfall <= 0;
    end else begin
      if (!prog_n) begin
        t_init <= 1'b0; t_done <= 1'b0; clr_cnt <= 0; dropped <= 1'b0;
        plow <= plow + 1;
        if (plow == 0) nfall <= nfall + 1;
      end else begin
        if (plow != 0) plow_last <= plow;
        plow <= 0;
        if (!t_init && !dropped && m_init_ok) begin
          if (clr_cnt == CLR - 1) t_init <= 1'b1;
          else clr_cnt <= clr_cnt + 1;
        end
        if (cclk && !cs_n) begin
          cap[ncap[5:0]] <= cdata;
          ncap <= ncap + 1;
          if (m_drop != 0 && ncap + 1 == int'(m_drop)) begin
            t_init <= 1'b0; dropped <= 1'b1;
          end
        end
        if (cclk && cs_n) nsu <= nsu + 1;
        if (m_done_ok && nsu >= 8 && t_init) t_done <= 1'b1;
      end
    end
  end

  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int k = 0; k < 8; k++) rev8[7-k] = b[k];
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    m_init_ok = v.init_ok; m_done_ok = v.done_ok; m_drop = v.drop;
    m_clr = 1'b1;
    @(negedge clk);
    m_clr = 1'b0;
    base = v.base; last = v.last; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic check_run(input vec_t v, input int idx);
    int bad = 0;
    chk(ecode == v.err, $sformatf("R3/R6/R7/R8/R9 err code vec %0d", idx), ecode, v.err);
    chk(err == (v.err != 0), $sformatf("R10 err flag vec %0d", idx), err, v.err != 0);
    chk(done == (v.err == 0), $sformatf("R9 done flag vec %0d", idx), done, v.err == 0);
    chk(ncap == int'(v.nbytes), $sformatf("R4 byte count vec %0d", idx), ncap, v.nbytes);
    for (int i = 0; i < ncap && i < 64; i++)
      if (cap[i] != rev8(mem[(int'(v.base) + i) % 64])) bad++;
    chk(bad == 0, $sformatf("R5 byte content vec %0d", idx), bad, 0);
    chk(nsu == int'(v.nsu), $sformatf("R9 startup pulses vec %0d", idx), nsu, v.nsu);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    for (int i = 0; i < 4; i++) begin
      mem[i] = 8'hFF; mem[32+i] = 8'hFF; mem[48+i] = 8'hFF; mem[16+i] = 8'hFF;
    end
    mem[4] = 8'hAA; mem[5] = 8'h99; mem[6] = 8'h55; mem[7] = 8'h66;
    mem[36] = 8'hAA; mem[37] = 8'h99; mem[38] = 8'h55; mem[39] = 8'h66;
    for (int i = 8; i < 16; i++) mem[i] = 8'(8'h13 + i * 29);
    mem[40] = 8'h3C; mem[41] = 8'h81; mem[42] = 8'h01; mem[43] = 8'hF0;
    mem[19] = 8'h00; mem[52] = 8'hAA;
    m_init_ok = 1'b1; m_done_ok = 1'b1; m_drop = 8'd0; m_clr = 1'b0;
    cyc = 0; plow_last = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset / idle state
    chk(prog_n == 1'b1, "R11 prog_n idle", prog_n, 1);
    chk(cs_n == 1'b1, "R11 cs_n idle", cs_n, 1);
    chk(cclk == 1'b0, "R11 cclk idle", cclk, 0);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(done == 1'b0 && err == 1'b0, "R10 flags after reset", {done, err}, 0);

    for (int v = 0; v < NV; v++) begin
      launch(VECS[v]);
      chk(busy == 1'b1, $sformatf("R1 busy after start vec %0d", v), busy, 1);
      wait_idle();
      check_run(VECS[v], v);
    end

    // R2 program pulse length and count
    launch(VECS[0]);
    // R1 start while busy is ignored
    repeat (30) @(negedge clk);
    base = 16'd32; last = 16'd43; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk(plow_last == 16, "R2 program low cycles", plow_last, 16);
    chk(nfall == 1, "R2 single program pulse", nfall, 1);
    chk(ncap == 16, "R1 busy start ignored bytes", ncap, 16);
    chk(done == 1'b1, "R1 busy start ignored done", done, 1);

    // R10 flags hold then clear on start
    repeat (40) @(negedge clk);
    chk(done == 1'b1 && err == 1'b0, "R10 done held", {done, err}, 2);
    launch(VECS[4]);
    chk(done == 1'b0 && err == 1'b0, "R10 flags cleared by start", {done, err}, 0);
    chk(prog_n == 1'b0, "R2 program low after start", prog_n, 0);
    wait_idle();
    chk(err == 1'b1 && ecode == 3'd1, "R3 init timeout again", ecode, 1);
    repeat (40) @(negedge clk);
    chk(err == 1'b1 && done == 1'b0, "R10 err held", {done, err}, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule